// File: doc/BRIEF.md
# Four-Phase Interpolating Root-Nyquist Pulse-Shaping Filter

This block shapes paired I and Q baseband samples with a 31-tap square-root Nyquist response and raises the rate by four. Every accepted input pair produces four output pairs, one for each polyphase branch, tagged 0 to 3. The I and Q channels each have a multiply-accumulate datapath. Both read one shared coefficient store, so the two channels always use the same taps, offset and shift. Each branch reduces its 20-bit accumulator in three steps: it adds its own signed 11-bit offset, applies an arithmetic right shift of 0 to 15 places chosen for that branch, and then saturates the result to a signed 10-bit word.

All settings enter through a byte-wide write strobe that acts as a 196-byte shift chain. Each written byte pushes the oldest one out, and the last 196 bytes written form the configuration. Phase 0 is written first and phase 3 last, 49 bytes per phase. The block refuses input and shows no valid output from the first byte of a load until the 196th byte has been taken. A new load also empties the sample history and drops any pending outputs.

Samples enter and leave over valid/ready handshakes. An input pair is taken on a clock edge where `in_valid` and `in_ready` are both high. An output pair leaves on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the output pair and its phase tag stay frozen. `in_ready` is asserted only when no branch outputs remain for the previous sample, or when its last branch output is leaving on this edge. Back-pressure on the output therefore stalls the input side without losing anything.

Top module: `pnf_nyquist_top`

## Requirements
- R1: After exactly 196 writes on `cfg_we`, the configuration equals those bytes in write order, and no byte written earlier has any effect. Bytes 0 to 48 form phase 0, bytes 49 to 97 phase 1, bytes 98 to 146 phase 2 and bytes 147 to 195 phase 3.
- R2: Within a phase block, bytes 0 to 11 hold eight 12-bit two's complement coefficients, packed little-endian, with slot k at bits 12k to 12k+11. Bytes 12 and 13 hold the offset in bits 10:0 of their little-endian 16-bit value. Bits 3:0 of byte 14 hold the shift. All other bits, and bytes 15 to 48, are ignored.
- R3: Slot k of phase p is prototype tap 4k+p. Slot 7 of phase 3 (tap 31) always acts as zero, whatever was loaded into it.
- R4: Each output is built in four steps. The sum over slots k of coef[p][k]*x[n-k] wraps to a signed 20-bit value. The sign-extended offset is added to it. The result is shifted arithmetically right by the phase's shift amount. That value is then clamped to the range -512 to 511.
- R5: All 16 shift amounts from 0 to 15 are honoured, and each phase applies its own amount.
- R6: I and Q are computed in the same cycle with the same coefficients, offset and shift.
- R7: Each accepted input pair yields exactly four outputs with `out_phase` equal to 0, 1, 2, 3 in that order.
- R8: The history holds the eight most recent accepted pairs, x[n] to x[n-7]. It advances only when an input is accepted.
- R9: While `out_valid` is high and `out_ready` is low, `out_i`, `out_q` and `out_phase` stay unchanged.
- R10: `cfg_done` is low from reset until a full load, and from the first byte of any load until its 196th byte. While it is low, `in_ready` and `out_valid` are both low. A load byte drops pending outputs and clears the history.
- R11: Synchronous reset clears the configuration and the history, sets the phase to 0, and drives `cfg_done` and `out_valid` low.
- R12: With every coefficient zero except tap 15 (phase 3, slot 3) set to 1, and with zero offset and zero shift, phases 0 to 2 output 0 and phase 3 outputs the input from three samples earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_byte | input | 8 | Configuration byte shifted in on `cfg_we` |
| cfg_done | output | 1 | High when a complete configuration is held |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Input pair will be taken this edge if offered |
| in_i | input | 8 | In-phase input sample, signed |
| in_q | input | 8 | Quadrature input sample, signed |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Downstream takes the output pair |
| out_i | output | 10 | In-phase filtered output, signed |
| out_q | output | 10 | Quadrature filtered output, signed |
| out_phase | output | 2 | Polyphase branch that produced the output pair |

## Verification
A wrong history entry or a misplaced field in the shift chain changes every following output pair, starting with the first pair after the input is accepted. A fault in the shift or offset of one phase corrupts only that phase's outputs, and the fault appears within four outputs of the first accepted sample. The bench therefore loads a fresh configuration for each of the 16 base shift amounts and compares every output word with an arithmetic model. A fault in the phase counter or the handshake logic shows up at the ports as a broken 0-1-2-3 tag order or as an output that moves while it is stalled.

// File: rtl/pnf_pkg.sv
package pnf_pkg;
  localparam int NPH_D    = 4;
  localparam int TPP_D    = 8;
  localparam int NTAPS_D  = 31;
  localparam int COEF_W_D = 12;
  localparam int IN_W_D   = 8;
  localparam int ACC_W_D  = 20;
  localparam int OFF_W_D  = 11;
  localparam int SH_W_D   = 4;
  localparam int OUT_W_D  = 10;
  localparam int BLK_D    = 49;

  function automatic int bytes_for(input int bits);
    return (bits + 7) / 8;
  endfunction
endpackage

// File: rtl/pnf_cfg_chain.sv
module pnf_cfg_chain
  import pnf_pkg::*;
#(
  parameter int NPH    = NPH_D,
  parameter int TPP    = TPP_D,
  parameter int NTAPS  = NTAPS_D,
  parameter int COEF_W = COEF_W_D,
  parameter int OFF_W  = OFF_W_D,
  parameter int SH_W   = SH_W_D,
  parameter int BLK    = BLK_D
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 we,
  input  logic [7:0]                           din,
  output logic                                 done,
  output logic [NPH-1:0][TPP-1:0][COEF_W-1:0]  coef_o,
  output logic [NPH-1:0][OFF_W-1:0]            off_o,
  output logic [NPH-1:0][SH_W-1:0]             sh_o
);
  localparam int TOTAL = NPH * BLK;
  localparam int CNT_W = $clog2(TOTAL);
  localparam int CB    = bytes_for(TPP * COEF_W);
  localparam int OB    = bytes_for(OFF_W);

  logic [7:0]       chain [TOTAL];
  logic [CNT_W-1:0] cnt;

  // Byte shift chain: oldest byte leaves at index 0, newest enters at the top.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TOTAL; i++) chain[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < TOTAL - 1; i++) chain[i] <= chain[i+1];
      chain[TOTAL-1] <= din;
    end
  end

  // Load progress: done drops on the first byte and rises on the last.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (we) begin
      if (cnt == CNT_W'(TOTAL - 1)) begin
        cnt  <= '0;
        done <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        done <= 1'b0;
      end
    end
  end

  // Field decode with constant byte and bit positions per phase block.
  for (genvar p = 0; p < NPH; p++) begin : g_ph
    for (genvar k = 0; k < TPP; k++) begin : g_slot
      for (genvar j = 0; j < COEF_W; j++) begin : g_bit
        localparam int POS = k * COEF_W + j;
        if (k * NPH + p < NTAPS) begin : g_live
          assign coef_o[p][k][j] = chain[p*BLK + POS/8][POS%8];
        end else begin : g_zero
          assign coef_o[p][k][j] = 1'b0;
        end
      end
    end
    for (genvar j = 0; j < OFF_W; j++) begin : g_off
      assign off_o[p][j] = chain[p*BLK + CB + j/8][j%8];
    end
    for (genvar j = 0; j < SH_W; j++) begin : g_sh
      assign sh_o[p][j] = chain[p*BLK + CB + OB + j/8][j%8];
    end
  end
endmodule

// File: rtl/pnf_delay.sv
module pnf_delay #(
  parameter int TPP  = pnf_pkg::TPP_D,
  parameter int IN_W = pnf_pkg::IN_W_D
) (
  input  logic                       clk,
  input  logic                       clr,
  input  logic                       push,
  input  logic [IN_W-1:0]            din,
  output logic [TPP-1:0][IN_W-1:0]   hist_o
);
  // hist_o[0] is the newest accepted sample.
  always_ff @(posedge clk) begin
    if (clr) begin
      hist_o <= '0;
    end else if (push) begin
      for (int k = TPP - 1; k > 0; k--) hist_o[k] <= hist_o[k-1];
      hist_o[0] <= din;
    end
  end
endmodule

// File: rtl/pnf_mac.sv
module pnf_mac #(
  parameter int TPP    = pnf_pkg::TPP_D,
  parameter int COEF_W = pnf_pkg::COEF_W_D,
  parameter int IN_W   = pnf_pkg::IN_W_D,
  parameter int ACC_W  = pnf_pkg::ACC_W_D,
  parameter int OFF_W  = pnf_pkg::OFF_W_D,
  parameter int SH_W   = pnf_pkg::SH_W_D,
  parameter int OUT_W  = pnf_pkg::OUT_W_D
) (
  input  logic [TPP-1:0][IN_W-1:0]    hist_i,
  input  logic [TPP-1:0][COEF_W-1:0]  coef_i,
  input  logic [OFF_W-1:0]            off_i,
  input  logic [SH_W-1:0]             sh_i,
  output logic [OUT_W-1:0]            y_o
);
  localparam int PROD_W = COEF_W + IN_W;
  localparam int PRE_W  = ((ACC_W > OFF_W) ? ACC_W : OFF_W) + 1;
  localparam logic signed [PRE_W-1:0] YMAX = PRE_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [PRE_W-1:0] YMIN = PRE_W'(-(1 << (OUT_W - 1)));

  logic signed [PROD_W-1:0] prod [TPP];
  logic signed [ACC_W-1:0]  acc;
  logic signed [PRE_W-1:0]  pre;
  logic signed [PRE_W-1:0]  shf;

  for (genvar k = 0; k < TPP; k++) begin : g_mul
    assign prod[k] = $signed(coef_i[k]) * $signed(hist_i[k]);
  end

  // Accumulate modulo 2^ACC_W.
  always_comb begin
    acc = '0;
    for (int k = 0; k < TPP; k++) acc = acc + ACC_W'(prod[k]);
  end

  assign pre = PRE_W'(acc) + PRE_W'($signed(off_i));
  assign shf = pre >>> sh_i;

  always_comb begin
    if (shf > YMAX)      y_o = YMAX[OUT_W-1:0];
    else if (shf < YMIN) y_o = YMIN[OUT_W-1:0];
    else                 y_o = shf[OUT_W-1:0];
  end
endmodule

// File: rtl/pnf_nyquist_top.sv
module pnf_nyquist_top
  import pnf_pkg::*;
#(
  parameter int NPH    = NPH_D,
  parameter int TPP    = TPP_D,
  parameter int NTAPS  = NTAPS_D,
  parameter int COEF_W = COEF_W_D,
  parameter int IN_W   = IN_W_D,
  parameter int ACC_W  = ACC_W_D,
  parameter int OFF_W  = OFF_W_D,
  parameter int SH_W   = SH_W_D,
  parameter int OUT_W  = OUT_W_D,
  parameter int BLK    = BLK_D,
  localparam int PH_W  = $clog2(NPH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_byte,
  output logic             cfg_done,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_i,
  input  logic [IN_W-1:0]  in_q,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_i,
  output logic [OUT_W-1:0] out_q,
  output logic [PH_W-1:0]  out_phase
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NPH - 1);

  logic [NPH-1:0][TPP-1:0][COEF_W-1:0] coef_all;
  logic [NPH-1:0][OFF_W-1:0]           off_all;
  logic [NPH-1:0][SH_W-1:0]            sh_all;

  logic [PH_W-1:0] ph;
  logic            armed;
  logic            adv, fire_in, emit, hist_clr;
  logic [1:0][IN_W-1:0]  smp;
  logic [1:0][OUT_W-1:0] y;

  pnf_cfg_chain #(
    .NPH(NPH), .TPP(TPP), .NTAPS(NTAPS), .COEF_W(COEF_W),
    .OFF_W(OFF_W), .SH_W(SH_W), .BLK(BLK)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .din(cfg_byte),
    .done(cfg_done), .coef_o(coef_all), .off_o(off_all), .sh_o(sh_all)
  );

  assign adv      = !out_valid || out_ready;
  assign in_ready = cfg_done && (!armed || (ph == PH_LAST && adv));
  assign fire_in  = in_valid && in_ready;
  assign emit     = cfg_done && armed && adv;
  assign hist_clr = rst || cfg_we;
  assign smp[0]   = in_i;
  assign smp[1]   = in_q;

  // One history and one MAC per channel; all share the selected phase bank.
  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [TPP-1:0][IN_W-1:0] hist;
    pnf_delay #(.TPP(TPP), .IN_W(IN_W)) u_dly (
      .clk(clk), .clr(hist_clr), .push(fire_in), .din(smp[c]), .hist_o(hist)
    );
    pnf_mac #(
      .TPP(TPP), .COEF_W(COEF_W), .IN_W(IN_W), .ACC_W(ACC_W),
      .OFF_W(OFF_W), .SH_W(SH_W), .OUT_W(OUT_W)
    ) u_mac (
      .hist_i(hist), .coef_i(coef_all[ph]), .off_i(off_all[ph]),
      .sh_i(sh_all[ph]), .y_o(y[c])
    );
  end

  // Phase sequencing and output register.
  always_ff @(posedge clk) begin
    if (rst || cfg_we) begin
      out_valid <= 1'b0;
      armed     <= 1'b0;
      ph        <= '0;
      if (rst) begin
        out_i     <= '0;
        out_q     <= '0;
        out_phase <= '0;
      end
    end else begin
      if (emit) begin
        out_valid <= 1'b1;
        out_i     <= y[0];
        out_q     <= y[1];
        out_phase <= ph;
        if (ph == PH_LAST) begin
          ph    <= '0;
          armed <= 1'b0;
        end else begin
          ph <= ph + 1'b1;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (fire_in) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/pnf_nyquist_chk.sv
module pnf_nyquist_chk #(
  parameter int OUT_W = 10,
  parameter int PH_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             cfg_done,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_i,
  input logic [OUT_W-1:0] out_q,
  input logic [PH_W-1:0]  out_phase
);
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q) && $stable(out_phase)));

  a_r10_quiet_unloaded: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |-> (!out_valid && !in_ready));

  a_r10_done_by_write: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> $past(cfg_we));

  a_r7_phase_step: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid || out_phase == PH_W'($past(out_phase) + 1'b1)));

  a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cfg_done && !out_valid));
endmodule

bind pnf_nyquist_top pnf_nyquist_chk #(.OUT_W(OUT_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_done(cfg_done),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_i(out_i), .out_q(out_q), .out_phase(out_phase)
);

// File: tb/tb_pnf_nyquist_top.sv
module tb_pnf_nyquist_top;
  localparam int NB = 196;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_byte = '0;
  logic cfg_done, in_ready, out_valid;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [7:0] in_i = '0, in_q = '0;
  logic [9:0] out_i, out_q;
  logic [1:0] out_phase;

  pnf_nyquist_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_byte(cfg_byte), .cfg_done(cfg_done),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
    .out_phase(out_phase)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] img [NB];
  logic [7:0] cfg_m [NB];
  int hist_m [2][8];
  int qi[$], qq[$], qp[$];
  string cur_req = "R4";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- arithmetic model (R2, R3, R4) ----------------
  function automatic int coefv(int p, int k);
    int bp = 12 * k;
    int b  = p * 49 + bp / 8;
    int w  = int'(cfg_m[b]) | (int'(cfg_m[b+1]) << 8);
    int v  = (w >> (bp % 8)) & 'hfff;
    if (4 * k + p >= 31) return 0;      // R3 tap 31 is dead
    if (v >= 2048) v -= 4096;
    return v;
  endfunction

  function automatic int model_y(int p, int ch);
    int acc = 0;
    int off, sh, y;
    for (int k = 0; k < 8; k++) acc += coefv(p, k) * hist_m[ch][k];
    acc = (acc <<< 12) >>> 12;           // wrap to signed 20 bits
    off = (int'(cfg_m[p*49+12]) | (int'(cfg_m[p*49+13]) << 8)) & 'h7ff;
    if (off >= 1024) off -= 2048;
    sh = int'(cfg_m[p*49+14]) & 15;
    y = (acc + off) >>> sh;
    if (y > 511) y = 511;
    if (y < -512) y = -512;
    return y;
  endfunction

  function automatic void set_coef(int p, int k, int v);
    int bp = 12 * k;
    int b  = p * 49 + bp / 8;
    int w  = int'(img[b]) | (int'(img[b+1]) << 8);
    w = (w & ~('hfff << (bp % 8))) | ((v & 'hfff) << (bp % 8));
    img[b]   = 8'(w);
    img[b+1] = 8'(w >> 8);
  endfunction

  function automatic void clear_model();
    for (int c = 0; c < 2; c++) for (int k = 0; k < 8; k++) hist_m[c][k] = 0;
    qi.delete(); qq.delete(); qp.delete();
  endfunction

  // Random image: every unused bit and pad byte filled with junk (R2).
  function automatic void build_random(int base_sh, int mag);
    for (int b = 0; b < NB; b++) img[b] = 8'($urandom_range(0, 255));
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 8; k++) set_coef(p, k, $urandom_range(0, 2 * mag) - mag);
      img[p*49+14] = 8'(((base_sh + p) % 16) | ($urandom_range(0, 15) << 4));
    end
  endfunction

  function automatic void build_bypass();
    for (int b = 0; b < NB; b++) img[b] = '0;
    set_coef(3, 3, 1);                   // prototype tap 15
  endfunction

  function automatic void build_sat();
    for (int b = 0; b < NB; b++) img[b] = '0;
    for (int p = 0; p < 4; p++) set_coef(p, 0, (p % 2 == 0) ? 2047 : -2048);
  endfunction

  // ---------------- load task (R1, R10) ----------------
  task automatic load_img();
    in_valid = 1'b0;
    for (int b = 0; b < NB; b++) begin
      cfg_we = 1'b1;
      cfg_byte = img[b];
      @(posedge clk); #1;
      if (b == 0 || b == 100) begin
        chk(cfg_done == 1'b0, "R10", "cfg_done during load", int'(cfg_done), 0);
        chk(out_valid == 1'b0, "R10", "out_valid during load", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R10", "in_ready during load", int'(in_ready), 0);
      end
    end
    cfg_we = 1'b0;
    chk(cfg_done == 1'b1, "R10", "cfg_done after 196 bytes", int'(cfg_done), 1);
    for (int b = 0; b < NB; b++) cfg_m[b] = img[b];
    clear_model();
  endtask

  function automatic int gen_smp(int idx, int ch);
    if (idx % 5 == 1) return ch ? -128 : 127;
    if (idx % 5 == 3) return ch ? 127 : -128;
    return $urandom_range(0, 255) - 128;
  endfunction

  // ---------------- streaming with model comparison ----------------
  task automatic stream(int n, bit bp);
    int sent = 0, guard = 0;
    int s0 = gen_smp(0, 0), s1 = gen_smp(0, 1);
    bit fi, fo;
    in_i = 8'(s0); in_q = 8'(s1); in_valid = 1'b1;
    out_ready = 1'b1;
    while ((sent < n || qi.size() > 0) && guard < 20000) begin
      guard++;
      @(negedge clk);
      fi = in_valid && in_ready;
      fo = out_valid && out_ready;
      if (fo) begin
        if (qi.size() == 0) begin
          chk(1'b0, "R7", "unexpected output", int'(out_phase), -1);
        end else begin
          chk(int'($signed(out_i)) == qi[0], cur_req, "out_i", int'($signed(out_i)), qi[0]);
          chk(int'($signed(out_q)) == qq[0], cur_req, "out_q (R6)", int'($signed(out_q)), qq[0]);
          chk(int'(out_phase) == qp[0], "R7", "out_phase", int'(out_phase), qp[0]);
          void'(qi.pop_front()); void'(qq.pop_front()); void'(qp.pop_front());
        end
      end
      if (fi) begin
        for (int k = 7; k > 0; k--) begin
          hist_m[0][k] = hist_m[0][k-1];
          hist_m[1][k] = hist_m[1][k-1];
        end
        hist_m[0][0] = s0; hist_m[1][0] = s1;
        for (int p = 0; p < 4; p++) begin
          qi.push_back(model_y(p, 0)); qq.push_back(model_y(p, 1)); qp.push_back(p);
        end
      end
      @(posedge clk); #1;
      if (fi) begin
        sent++;
        if (sent < n) begin
          s0 = gen_smp(sent, 0); s1 = gen_smp(sent, 1);
          in_i = 8'(s0); in_q = 8'(s1);
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = bp ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    chk(qi.size() == 0, cur_req, "outputs drained", qi.size(), 0);
  endtask

  initial begin
    logic [9:0] held;
    // R11 reset state
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(cfg_done == 1'b0, "R11", "cfg_done after reset", int'(cfg_done), 0);
    chk(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R10", "in_ready before any load", int'(in_ready), 0);

    // R12 bypass
    build_bypass();
    load_img();
    cur_req = "R12";
    stream(40, 1'b0);

    // R9 stall hold, then R10 flush by a new load
    in_i = 8'(77); in_q = 8'(-5); in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk(out_valid == 1'b1, "R9", "out_valid while stalled", int'(out_valid), 1);
    chk(out_phase == 2'd0, "R7", "first phase tag", int'(out_phase), 0);
    held = out_i;
    repeat (3) @(posedge clk); #1;
    chk(out_i == held, "R9", "out_i stable while stalled", int'(out_i), int'(held));
    chk(in_ready == 1'b0, "R9", "in_ready with branches pending", int'(in_ready), 0);
    out_ready = 1'b1;
    build_random(0, 200);
    load_img();                           // first-byte check covers the flush

    // R5 sweep of every base shift with per-phase shifts, under back-pressure
    cur_req = "R2 R3 R5 R8";
    for (int s = 0; s < 16; s++) begin
      build_random(s, (s < 4) ? 60 : 2047);
      load_img();
      stream(16, 1'b1);
    end

    // R4 saturation and wrap
    cur_req = "R4";
    build_sat();
    load_img();
    stream(24, 1'b0);
    build_random(2, 2047);
    load_img();
    stream(24, 1'b1);

    // R1 two back-to-back loads: only the second governs
    build_random(7, 300);
    load_img();
    build_random(1, 100);
    load_img();
    cur_req = "R1";
    stream(24, 1'b1);

    // R11 reset in mid-stream state
    in_i = 8'(9); in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    chk(cfg_done == 1'b0, "R11", "cfg_done after second reset", int'(cfg_done), 0);
    chk(out_valid == 1'b0, "R11", "out_valid after second reset", int'(out_valid), 0);
    build_bypass();
    load_img();
    cur_req = "R11 R12";
    stream(12, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule